// File: doc/BRIEF.md
# Programmable CPU Address Decode Windows

This block holds a bank of programmable windows that route CPU physical addresses (36 bits) to on-chip devices. Each window is programmed through a small word-wide register port with a control word (enable, a 4-bit device target, an 8-bit device attribute and a size) and a base word. The lowest-numbered windows also carry a remap base. An address that falls inside an enabled window is tagged with that window's target and attribute. If the window is remappable, the address is also translated to the remap base.

The lookup is purely combinational from the request address and the programmed state. The decision (hit, miss, multiple hit), the winning window index, the device identity and the translated address are all valid in the same cycle as the request. Register writes take effect at the clock edge. Register reads are combinational from the read address.

Top module: `adw_decoder`

## Requirements
- R1: After a synchronous reset every window is disabled, every register reads zero, and every request address reports a miss.
- R2: The control word holds enable in bit 0, target in bits 7:4, attribute in bits 15:8 and size-minus-one in 64 KB units in bits 31:16. Bits 3:1 read back as zero. The base word holds address bits 31:16 in bits 31:16 and address bits 35:32 in bits 3:0, and every other bit reads zero. The remap-high word keeps only bits 3:0.
- R3: Remappable window w (w < NUM_REMAP) has control at byte w·16, base at +4, remap-low (address bits 31:16 in bits 31:16) at +8 and remap-high (address bits 35:32 in bits 3:0) at +12. A reserved gap of GAP_BYTES bytes follows. The other windows use an 8-byte stride with control at +0 and base at +4. The gap, offsets past the last window and misaligned offsets read zero, and writes to them change nothing.
- R4: A window whose enable bit is clear never hits, even when the address lies in its range.
- R5: A window hits when the address is at or above its base and below base + ((size field << 16) | 0xFFFF) + 1. The last byte of the range hits and the next byte does not.
- R6: When several enabled windows hit, the lowest index wins and the multi-hit output is high. With a single hit it is low.
- R7: A hit on a remappable window outputs remap base + (address − window base) on 36 bits, so the low 16 address bits pass unchanged.
- R8: A hit on a window with index NUM_REMAP or above outputs the request address unchanged.
- R9: With no hit, miss is high, hit is low, target and attribute are zero and the address passes unchanged.
- R10: Base bits 35:32 take part in the compare, so windows can sit above the 4 GB line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_addr | input | 36 | CPU physical address to decode |
| hit | output | 1 | Some enabled window holds req_addr |
| miss | output | 1 | No enabled window holds req_addr |
| multi_hit | output | 1 | More than one enabled window holds req_addr |
| win_idx | output | IDX_W (5) | Index of the winning window (zero on miss) |
| tgt | output | 4 | Target of the winning window |
| attr | output | 8 | Attribute of the winning window |
| out_addr | output | 36 | Translated or passed-through address |

## Verification
Two functions can act on one address at the same time. A remappable window and a wide upper window are programmed to overlap, so priority selection and remap translation both decide the output for a single request. Addresses at the start and end of the low window and just past it are judged on the winning index, the multi-hit flag and whether the output address is translated or passed through. The low window is then disabled, and the same address must fall to the upper window, pass through untranslated, and no longer report a multiple hit.

// File: rtl/adw_pkg.sv
package adw_pkg;

   localparam int PA_W = 36;          // physical address width
   localparam int GRAN_W = 16;        // 64 KB granule
   localparam int PG_W = PA_W - GRAN_W;

   typedef struct packed {
      logic            en;
      logic [3:0]      tgt;
      logic [7:0]      attr;
      logic [15:0]     size_m1;
      logic [PG_W-1:0] base_pg;
      logic [PG_W-1:0] remap_pg;
   } win_cfg_t;

   // byte offset of window w's control word
   function automatic int win_offset(int w, int nrem, int gap);
      if (w < nrem) return w * 16;
      return nrem * 16 + gap + (w - nrem) * 8;
   endfunction

endpackage

// File: rtl/adw_regfile.sv
module adw_regfile
   import adw_pkg::*;
#(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   parameter int GAP_BYTES = 16,
   parameter int REG_AW    = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      reg_we,
   input  logic [REG_AW-1:0]         reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   output win_cfg_t [NUM_WIN-1:0]    cfg
);

   logic [31:0] rd_part [NUM_WIN];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int OFF = win_offset(w, NUM_REMAP, GAP_BYTES);
      localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFF);
      localparam logic [REG_AW-1:0] A_BASE = REG_AW'(OFF + 4);

      logic        en_q;
      logic [3:0]  tgt_q;
      logic [7:0]  attr_q;
      logic [15:0] size_q;
      logic [15:0] blo_q;
      logic [3:0]  bhi_q;
      logic        sel_ctrl, sel_base;
      logic [31:0] rd_rm;
      logic [PG_W-1:0] rm_pg;

      assign sel_ctrl = (reg_addr == A_CTRL);
      assign sel_base = (reg_addr == A_BASE);

      always_ff @(posedge clk) begin
         if (rst) begin
            en_q   <= 1'b0;
            tgt_q  <= '0;
            attr_q <= '0;
            size_q <= '0;
            blo_q  <= '0;
            bhi_q  <= '0;
         end else if (reg_we) begin
            if (sel_ctrl) begin
               en_q   <= reg_wdata[0];
               tgt_q  <= reg_wdata[7:4];
               attr_q <= reg_wdata[15:8];
               size_q <= reg_wdata[31:16];
            end
            if (sel_base) begin
               blo_q <= reg_wdata[31:16];
               bhi_q <= reg_wdata[3:0];
            end
         end
      end

      if (w < NUM_REMAP) begin : g_rm
         localparam logic [REG_AW-1:0] A_RLO = REG_AW'(OFF + 8);
         localparam logic [REG_AW-1:0] A_RHI = REG_AW'(OFF + 12);
         logic [15:0] rlo_q;
         logic [3:0]  rhi_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               rlo_q <= '0;
               rhi_q <= '0;
            end else if (reg_we) begin
               if (reg_addr == A_RLO) rlo_q <= reg_wdata[31:16];
               if (reg_addr == A_RHI) rhi_q <= reg_wdata[3:0];
            end
         end
         assign rd_rm = (reg_addr == A_RLO) ? {rlo_q, 16'h0} :
                        (reg_addr == A_RHI) ? {28'h0, rhi_q} : 32'h0;
         assign rm_pg = {rhi_q, rlo_q};
      end else begin : g_plain
         assign rd_rm = 32'h0;
         assign rm_pg = '0;
      end

      assign rd_part[w] = sel_ctrl ? {size_q, attr_q, tgt_q, 3'b000, en_q} :
                          sel_base ? {blo_q, 12'h000, bhi_q} : rd_rm;

      assign cfg[w] = '{en: en_q, tgt: tgt_q, attr: attr_q, size_m1: size_q,
                        base_pg: {bhi_q, blo_q}, remap_pg: rm_pg};
   end

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NUM_WIN; w++) reg_rdata |= rd_part[w];
   end

endmodule

// File: rtl/adw_match.sv
module adw_match
   import adw_pkg::*;
#(
   parameter int NUM_WIN = 20
) (
   input  logic [PG_W-1:0]                pg,
   input  logic [NUM_WIN-1:0]             en,
   input  logic [NUM_WIN-1:0][PG_W-1:0]   base_pg,
   input  logic [NUM_WIN-1:0][15:0]       size_m1,
   output logic [NUM_WIN-1:0]             hit
);

   localparam int EW = PG_W + 1;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      logic [EW-1:0] end_pg;   // exclusive end, in granules
      assign end_pg = EW'(base_pg[w]) + EW'(size_m1[w]) + EW'(1);
      assign hit[w] = en[w] && (pg >= base_pg[w]) && (EW'(pg) < end_pg);
   end

endmodule

// File: rtl/adw_select.sv
module adw_select
   import adw_pkg::*;
#(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   localparam int IDX_W    = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0]          hit_vec,
   input  win_cfg_t [NUM_WIN-1:0]      cfg,
   input  logic [PA_W-1:0]             req_addr,
   output logic                        hit,
   output logic                        miss,
   output logic                        multi_hit,
   output logic [IDX_W-1:0]            win_idx,
   output logic [3:0]                  tgt,
   output logic [7:0]                  attr,
   output logic [PA_W-1:0]             out_addr
);

   logic [IDX_W-1:0] sel;
   logic             sel_rm;
   win_cfg_t         c;
   logic [PG_W-1:0]  xl_pg;
   logic             unused_fields;

   // scan downward so the lowest hitting index is left in sel
   always_comb begin
      sel    = '0;
      sel_rm = 1'b0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            sel    = IDX_W'(i);
            sel_rm = (i < NUM_REMAP);
         end
      end
   end

   assign c         = cfg[sel];
   assign hit       = |hit_vec;
   assign miss      = ~hit;
   assign multi_hit = (hit_vec & (hit_vec - 1'b1)) != '0;
   assign xl_pg     = c.remap_pg + (req_addr[PA_W-1:GRAN_W] - c.base_pg);

   assign win_idx  = sel;
   assign tgt      = hit ? c.tgt  : 4'h0;
   assign attr     = hit ? c.attr : 8'h00;
   assign out_addr = (hit && sel_rm) ? {xl_pg, req_addr[GRAN_W-1:0]} : req_addr;

   assign unused_fields = ^{c.en, c.size_m1};

endmodule

// File: rtl/adw_decoder.sv
module adw_decoder
   import adw_pkg::*;
#(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   parameter int GAP_BYTES = 16,
   parameter int REG_AW    = 8,
   localparam int IDX_W    = $clog2(NUM_WIN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [PA_W-1:0]   req_addr,
   output logic              hit,
   output logic              miss,
   output logic              multi_hit,
   output logic [IDX_W-1:0]  win_idx,
   output logic [3:0]        tgt,
   output logic [7:0]        attr,
   output logic [PA_W-1:0]   out_addr
);

   localparam int MAP_END = win_offset(NUM_WIN, NUM_REMAP, GAP_BYTES);

   if (NUM_WIN < 2) begin : g_bad_nwin
      $error("adw_decoder: NUM_WIN must be at least 2");
   end
   if (NUM_REMAP > NUM_WIN) begin : g_bad_nrem
      $error("adw_decoder: NUM_REMAP exceeds NUM_WIN");
   end
   if (GAP_BYTES % 8 != 0) begin : g_bad_gap
      $error("adw_decoder: GAP_BYTES must be a multiple of 8");
   end
   if (MAP_END > (1 << REG_AW)) begin : g_bad_aw
      $error("adw_decoder: REG_AW too narrow for the register map");
   end

   win_cfg_t [NUM_WIN-1:0]           cfg;
   logic [NUM_WIN-1:0]               en_v;
   logic [NUM_WIN-1:0][PG_W-1:0]     base_v;
   logic [NUM_WIN-1:0][15:0]         size_v;
   logic [NUM_WIN-1:0]               hit_vec;

   adw_regfile #(
      .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP),
      .GAP_BYTES(GAP_BYTES), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_unpack
      assign en_v[w]   = cfg[w].en;
      assign base_v[w] = cfg[w].base_pg;
      assign size_v[w] = cfg[w].size_m1;
   end

   adw_match #(.NUM_WIN(NUM_WIN)) u_match (
      .pg(req_addr[PA_W-1:GRAN_W]), .en(en_v), .base_pg(base_v),
      .size_m1(size_v), .hit(hit_vec)
   );

   adw_select #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_sel (
      .hit_vec(hit_vec), .cfg(cfg), .req_addr(req_addr),
      .hit(hit), .miss(miss), .multi_hit(multi_hit), .win_idx(win_idx),
      .tgt(tgt), .attr(attr), .out_addr(out_addr)
   );

endmodule

// File: rtl/adw_decoder_chk.sv
module adw_decoder_chk #(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   parameter int GAP_BYTES = 16,
   parameter int REG_AW    = 8,
   localparam int IDX_W    = $clog2(NUM_WIN)
) (
   input logic              clk,
   input logic              rst,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic [35:0]       req_addr,
   input logic              hit,
   input logic              miss,
   input logic              multi_hit,
   input logic [IDX_W-1:0]  win_idx,
   input logic [3:0]        tgt,
   input logic [7:0]        attr,
   input logic [35:0]       out_addr
);

   localparam int GAP_LO = NUM_REMAP * 16;

   AST_RESET_ALL_MISS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> miss);  // R1

   AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (int'(reg_addr) >= GAP_LO && int'(reg_addr) < GAP_LO + GAP_BYTES)
      |-> reg_rdata == 32'h0);  // R3

   AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
      multi_hit |-> hit);  // R6

   AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
      hit |-> out_addr[15:0] == req_addr[15:0]);  // R7

   AST_UPPER_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
      (hit && int'(win_idx) >= NUM_REMAP) |-> out_addr == req_addr);  // R8

   AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
      miss |-> (tgt == 4'h0 && attr == 8'h00 && out_addr == req_addr));  // R9

endmodule

bind adw_decoder adw_decoder_chk #(
   .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP),
   .GAP_BYTES(GAP_BYTES), .REG_AW(REG_AW)
) u_chk (
   .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .req_addr(req_addr), .hit(hit), .miss(miss), .multi_hit(multi_hit),
   .win_idx(win_idx), .tgt(tgt), .attr(attr), .out_addr(out_addr)
);

// File: tb/adw_decoder_test.sv
module adw_decoder_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [35:0] req_addr = '0;
   logic        hit, miss, multi_hit;
   logic [4:0]  win_idx;
   logic [3:0]  tgt;
   logic [7:0]  attr;
   logic [35:0] out_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   adw_decoder uut (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
      .hit(hit), .miss(miss), .multi_hit(multi_hit), .win_idx(win_idx),
      .tgt(tgt), .attr(attr), .out_addr(out_addr)
   );

   typedef struct packed {
      logic [35:0] a;
      logic        h;
      logic        m;
      logic [4:0]  idx;
      logic [3:0]  t;
      logic [7:0]  at;
      logic [35:0] o;
   } vec_t;

   // windows: 0 remap 0x1000_0000/1MB -> 0x2_4000_0000; 1 disabled at 0x3000_0000;
   // 2 remap 0x2000_0000/64KB -> 0; 9 at 0x1_0000_0000/16MB; 12 at 0x1000_0000/256MB;
   // 19 at 0xF_FFFF_0000/64KB
   localparam vec_t VECS [13] = '{
      '{36'h0_1000_0000, 1'b1, 1'b1, 5'd0,  4'h4, 8'hE0, 36'h2_4000_0000}, // R6 R7
      '{36'h0_100F_FFFF, 1'b1, 1'b1, 5'd0,  4'h4, 8'hE0, 36'h2_400F_FFFF}, // R5 R7
      '{36'h0_1010_0000, 1'b1, 1'b0, 5'd12, 4'h8, 8'hD0, 36'h0_1010_0000}, // R5 R8
      '{36'h0_0FFF_FFFF, 1'b0, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0_0FFF_FFFF}, // R9
      '{36'h0_3000_0000, 1'b0, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0_3000_0000}, // R4
      '{36'h0_2000_1234, 1'b1, 1'b0, 5'd2,  4'h3, 8'h01, 36'h0_0000_1234}, // R7
      '{36'h0_2001_0000, 1'b0, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0_2001_0000}, // R5
      '{36'h1_0000_0000, 1'b1, 1'b0, 5'd9,  4'h1, 8'h2F, 36'h1_0000_0000}, // R10
      '{36'h1_00FF_FFFF, 1'b1, 1'b0, 5'd9,  4'h1, 8'h2F, 36'h1_00FF_FFFF}, // R5 R10
      '{36'h1_0100_0000, 1'b0, 1'b0, 5'd0,  4'h0, 8'h00, 36'h1_0100_0000}, // R5
      '{36'h0_1FFF_FFFF, 1'b1, 1'b0, 5'd12, 4'h8, 8'hD0, 36'h0_1FFF_FFFF}, // R5 R8
      '{36'hF_FFFF_FFFF, 1'b1, 1'b0, 5'd19, 4'hD, 8'h00, 36'hF_FFFF_FFFF}, // R10
      '{36'h0_2000_0000, 1'b1, 1'b0, 5'd2,  4'h3, 8'h01, 36'h0_0000_0000}  // R5 R7
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata === exp, req, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic look(input vec_t v, input string req);
      @(negedge clk);
      req_addr = v.a;
      #1;
      check(hit === v.h && miss === !v.h, {req, " hit"}, 64'(hit), 64'(v.h));
      check(multi_hit === v.m, {req, " multi"}, 64'(multi_hit), 64'(v.m));
      if (v.h) check(win_idx === v.idx, {req, " idx"}, 64'(win_idx), 64'(v.idx));
      check(tgt === v.t && attr === v.at, {req, " id"}, 64'({tgt, attr}), 64'({v.t, v.at}));
      check(out_addr === v.o, {req, " addr"}, 64'(out_addr), 64'(v.o));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      rd_chk(8'h00, 32'h0, "R1 ctrl0 after reset");
      rd_chk(8'hE8, 32'h0, "R1 ctrl19 after reset");
      look('{36'h0_1000_0000, 1'b0, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0_1000_0000}, "R1 lookup after reset");

      // program windows
      wr(8'h00, 32'h000F_E041); wr(8'h04, 32'h1000_0000);
      wr(8'h08, 32'h4000_0000); wr(8'h0C, 32'h0000_0002);
      wr(8'h10, 32'h0000_1D10); wr(8'h14, 32'h3000_0000);
      wr(8'h20, 32'h0000_0131); wr(8'h24, 32'h2000_0000);
      wr(8'h98, 32'h00FF_2F11); wr(8'h9C, 32'h0000_0001);
      wr(8'hB0, 32'h0FFF_D081); wr(8'hB4, 32'h1000_0000);
      wr(8'hE8, 32'h0000_00D1); wr(8'hEC, 32'hFFFF_000F);

      // R2: field layout and masking
      rd_chk(8'h00, 32'h000F_E041, "R2 ctrl0 readback");
      rd_chk(8'h9C, 32'h0000_0001, "R10 base9 high bits");
      wr(8'h40, 32'hFFFF_FFFE);
      rd_chk(8'h40, 32'hFFFF_FFF0, "R2 ctrl4 reserved bits");
      wr(8'h54, 32'hFFFF_FFFF);
      rd_chk(8'h54, 32'hFFFF_000F, "R2 base5 mask");
      wr(8'h3C, 32'hFFFF_FFFF);
      rd_chk(8'h3C, 32'h0000_000F, "R2 remap-high3 mask");
      rd_chk(8'h08, 32'h4000_0000, "R3 remap-low0 offset");

      // R3: gap, beyond-end and misaligned slots
      wr(8'h80, 32'hFFFF_FFFF); wr(8'h88, 32'hFFFF_FFFF); wr(8'h8C, 32'hFFFF_FFFF);
      wr(8'hF0, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
      rd_chk(8'h80, 32'h0, "R3 gap read");
      rd_chk(8'h8C, 32'h0, "R3 gap end read");
      rd_chk(8'hF0, 32'h0, "R3 past end read");
      rd_chk(8'h01, 32'h0, "R3 misaligned read");
      rd_chk(8'h00, 32'h000F_E041, "R3 ctrl0 untouched");
      rd_chk(8'h90, 32'h0, "R3 ctrl8 untouched");

      for (int i = 0; i < 13; i++) look(VECS[i], $sformatf("R4/R5/R6/R7/R8/R9/R10 vec %0d", i));

      // R6: priority changes once the low window is disabled
      wr(8'h00, 32'h000F_E040);
      look('{36'h0_1000_0000, 1'b1, 1'b0, 5'd12, 4'h8, 8'hD0, 36'h0_1000_0000}, "R6 fallback");
      look('{36'h0_2000_1234, 1'b1, 1'b0, 5'd2, 4'h3, 8'h01, 36'h0_0000_1234}, "R7 other remap");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule